// File: doc/BRIEF.md
# Symmetric linear-phase FIR filter

This block is a fixed-length, single-rate FIR filter that accepts one signed sample per clock. It relies on the mirrored structure of linear-phase coefficient sets: the taps at positions k and NTAPS-1-k share one coefficient. It therefore stores only the unique half of the coefficients and needs only that many multipliers. Samples enter a tapped delay line. Each mirrored pair of taps is combined first, then multiplied by its shared coefficient. The products are summed in a registered adder tree and leave as one full-precision result per input sample.

A single mode pin selects between two behaviours. In even-symmetry mode each tap pair is summed. In odd-symmetry mode the far tap of each pair is subtracted from the near tap. Odd symmetry suits differentiators and phase-shifting filters. Rounding and saturation are left to the consumer. Both stream interfaces use valid/ready handshakes. A sample transfers on a rising edge where valid and ready are both high. A producer that raises valid keeps it and its data steady until the transfer happens. When the consumer holds `res_ready` low while a result is waiting, the whole pipeline freezes: `smp_ready` drops in that same cycle and the pending result stays unchanged. The coefficient and mode pins are plain control inputs and are held steady while samples are in flight.

Top module: `symfir`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` is 0 and `smp_ready` is 1. The delay line starts cleared, so samples from before reset never reach a result.
- R2: With `odd_sym`=0, the result for the n-th accepted sample x[n] is the sum over k of c(k)·x[n-k]. For k below NTAPS/2, c(k) is the coefficient in field k of `coef_half` (bits k·CW up to k·CW+CW-1, two's complement), and c(NTAPS-1-k) equals c(k).
- R3: With `odd_sym`=1, c(NTAPS-1-k) is the negative of field k for each k below NTAPS/2. The far tap of each pair is subtracted from the near tap.
- R4: For odd NTAPS the centre field (index NTAPS/2) multiplies x[n-NTAPS/2] alone in even-symmetry mode. In odd-symmetry mode the centre tap contributes zero, whatever that field holds.
- R5: `res_data` is DW+1+CW+ceil(log2((NTAPS+1)/2)) bits wide and never wraps. All-minimum samples and coefficients give the exact result.
- R6: With `res_ready` held at 1, `res_valid` rises exactly LAT=2+ceil(log2((NTAPS+1)/2)) rising edges after the edge that accepts the sample. With the defaults LAT is 4.
- R7: `smp_ready` equals NOT `res_valid` OR `res_ready`. While `res_valid` is 1 and `res_ready` is 0, the next cycle still shows `res_valid`=1 with `res_data` unchanged.
- R8: Each accepted sample yields exactly one result, and results come out in acceptance order. Cycles with `smp_valid`=0 yield no result.
- R9: At most LAT+1 accepted samples are outstanding, that is, accepted but not yet delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| odd_sym | input | 1 | 0 = pairs are summed, 1 = pairs are subtracted |
| coef_half | input | NU*CW | Unique coefficients, field k at bits k*CW and up |
| smp_valid | input | 1 | Input sample present |
| smp_ready | output | 1 | Block can take a sample |
| smp_data | input | DW | Signed input sample |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | AW | Signed full-precision result |

## Verification
A stale or uncleared delay-line entry, or a wrong sign in one pair combiner, corrupts the first result whose window covers that tap. This shows at the output within LAT cycles of the sample that exposes it. An impulse therefore shows each tap position in turn, and mixed-sign data shows a misrouted pair. A fault in the valid chain or the stall enable shows up at once in the handshake pins. The result comes out at the wrong cycle, the pending data changes under back-pressure, or the count of results differs from the count of accepted samples. The bench models a plain direct-form convolution and compares every result against it. It sweeps impulse, constant, alternating-extreme and pseudo-random data across both modes, with input gaps and output stalls.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

  // number of distinct coefficients for a mirrored tap set
  function automatic int unique_count(input int ntaps);
    return (ntaps + 1) / 2;
  endfunction

  // levels of a binary tree over the given leaf count
  function automatic int tree_depth(input int leaves);
    int d;
    d = 0;
    while ((1 << d) < leaves) d++;
    return d;
  endfunction

  typedef enum logic {
    PAIR_ADD = 1'b0,
    PAIR_SUB = 1'b1
  } pair_op_e;

endpackage

// File: rtl/symfir_taps.sv
module symfir_taps #(
  parameter int NTAPS = 7,
  parameter int DW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift,
  input  logic [DW-1:0]         din,
  output logic [NTAPS*DW-1:0]   taps
);

  // slot 0 holds the newest sample, slot NTAPS-1 the oldest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '0;
    end else if (shift) begin
      taps <= {taps[(NTAPS-1)*DW-1:0], din};
    end
  end

endmodule

// File: rtl/symfir_fold.sv
module symfir_fold #(
  parameter int NTAPS = 7,
  parameter int DW    = 8,
  localparam int NU   = symfir_pkg::unique_count(NTAPS),
  localparam int PW   = DW + 1,
  localparam int HALF = NTAPS / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  symfir_pkg::pair_op_e  op,
  input  logic [NTAPS*DW-1:0]   taps,
  output logic [NU*PW-1:0]      pre
);

  localparam bit HAS_CENTRE = (NTAPS % 2) == 1;

  logic [NU*PW-1:0] pre_d;

  always_comb begin
    pre_d = '0;
    for (int j = 0; j < HALF; j++) begin
      if (op == symfir_pkg::PAIR_SUB)
        pre_d[j*PW +: PW] = PW'($signed(taps[j*DW +: DW]))
                          - PW'($signed(taps[(NTAPS-1-j)*DW +: DW]));
      else
        pre_d[j*PW +: PW] = PW'($signed(taps[j*DW +: DW]))
                          + PW'($signed(taps[(NTAPS-1-j)*DW +: DW]));
    end
    if (HAS_CENTRE) begin
      // unpaired middle tap; it carries no weight under odd symmetry
      if (op == symfir_pkg::PAIR_SUB)
        pre_d[HALF*PW +: PW] = '0;
      else
        pre_d[HALF*PW +: PW] = PW'($signed(taps[HALF*DW +: DW]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
    end else if (en) begin
      pre <= pre_d;
    end
  end

endmodule

// File: rtl/symfir_tree.sv
module symfir_tree #(
  parameter int NU = 4,
  parameter int PW = 9,
  parameter int CW = 8,
  localparam int LV = symfir_pkg::tree_depth(NU),
  localparam int AW = PW + CW + LV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [NU*PW-1:0]   pre,
  input  logic [NU*CW-1:0]   coefs,
  output logic [AW-1:0]      sum
);

  localparam int LEAVES = 1 << LV;
  localparam int NODES  = 2 * LEAVES - 1;

  logic signed [AW-1:0] prod [NU];
  // heap layout: node 0 is the root, leaves sit at LEAVES-1 and up
  logic signed [AW-1:0] node [NODES];

  always_comb begin
    for (int j = 0; j < NU; j++) begin
      prod[j] = AW'($signed(pre[j*PW +: PW])) * AW'($signed(coefs[j*CW +: CW]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NODES; i++) node[i] <= '0;
    end else if (en) begin
      for (int j = 0; j < LEAVES; j++) begin
        if (j < NU) node[LEAVES-1+j] <= prod[j];
        else        node[LEAVES-1+j] <= '0;
      end
      for (int i = 0; i < LEAVES - 1; i++) begin
        node[i] <= node[2*i+1] + node[2*i+2];
      end
    end
  end

  assign sum = node[0];

endmodule

// File: rtl/symfir.sv
module symfir #(
  parameter int NTAPS = 7,
  parameter int DW    = 8,
  parameter int CW    = 8,
  localparam int NU   = symfir_pkg::unique_count(NTAPS),
  localparam int LV   = symfir_pkg::tree_depth(NU),
  localparam int AW   = DW + 1 + CW + LV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               odd_sym,
  input  logic [NU*CW-1:0]   coef_half,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [DW-1:0]      smp_data,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [AW-1:0]      res_data
);

  localparam int PW     = DW + 1;
  localparam int STAGES = 3 + LV;   // taps, pre-combine, product, tree levels

  logic                  adv;
  logic                  take;
  logic [NTAPS*DW-1:0]   taps;
  logic [NU*PW-1:0]      pre;
  logic [STAGES-1:0]     vld;
  symfir_pkg::pair_op_e  op;

  // the whole pipeline moves unless a finished result is waiting
  assign adv       = !res_valid || res_ready;
  assign smp_ready = adv;
  assign take      = smp_valid && adv;
  assign op        = symfir_pkg::pair_op_e'(odd_sym);

  symfir_taps #(.NTAPS(NTAPS), .DW(DW)) u_taps (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (take),
    .din   (smp_data),
    .taps  (taps)
  );

  symfir_fold #(.NTAPS(NTAPS), .DW(DW)) u_fold (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .op    (op),
    .taps  (taps),
    .pre   (pre)
  );

  symfir_tree #(.NU(NU), .PW(PW), .CW(CW)) u_tree (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .pre   (pre),
    .coefs (coef_half),
    .sum   (res_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (adv) begin
      vld <= {vld[STAGES-2:0], take};
    end
  end

  assign res_valid = vld[STAGES-1];

endmodule

// File: rtl/symfir_chk.sv
module symfir_chk #(
  parameter int NTAPS = 7,
  parameter int DW    = 8,
  parameter int CW    = 8,
  localparam int NU   = symfir_pkg::unique_count(NTAPS),
  localparam int LV   = symfir_pkg::tree_depth(NU),
  localparam int AW   = DW + 1 + CW + LV
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [AW-1:0]    res_data
);

  localparam int LAT = 2 + LV;

  int inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= 0;
    else inflight <= inflight + int'(smp_valid && smp_ready) - int'(res_valid && res_ready);
  end

  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !res_valid);

  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  a_r7_input_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !smp_ready);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (inflight > 0));

  a_r9_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= LAT + 1);

endmodule

bind symfir symfir_chk #(.NTAPS(NTAPS), .DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data)
);

// File: tb/symfir_test.sv
module symfir_test;

  localparam int CLK_PERIOD = 10;
  localparam int NTAPS = 7;
  localparam int DW    = 8;
  localparam int CW    = 8;
  localparam int NU    = 4;
  localparam int LV    = 2;
  localparam int AW    = DW + 1 + CW + LV;
  localparam int LAT   = 2 + LV;
  localparam int MAXS  = 1024;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               odd_sym = 1'b0;
  logic [NU*CW-1:0]   coef_half;
  logic               smp_valid = 1'b0;
  logic               smp_ready;
  logic [DW-1:0]      smp_data = '0;
  logic               res_valid;
  logic               res_ready = 1'b1;
  logic [AW-1:0]      res_data;

  logic signed [CW-1:0] h [NU];

  always_comb begin
    for (int j = 0; j < NU; j++) coef_half[j*CW +: CW] = h[j];
  end

  symfir #(.NTAPS(NTAPS), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .odd_sym(odd_sym), .coef_half(coef_half),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int     nchk = 0;
  int     nfail = 0;
  int     iter = 0;
  int     nacc = 0;
  int     nout = 0;
  longint hist [MAXS];
  longint expq [MAXS];
  int     acc_iter [MAXS];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (iteration %0d)", req, act, exp, iter);
    end
  endtask

  // plain direct-form convolution over the accepted history
  function automatic longint model(input int n);
    longint s = 0;
    for (int k = 0; k < NTAPS; k++) begin
      longint x;
      longint c;
      int half = NTAPS / 2;
      x = (n - k >= 0) ? hist[n-k] : 0;
      if (k < half) c = h[k];
      else if ((NTAPS % 2 == 1) && k == half) c = odd_sym ? 0 : h[half];
      else c = odd_sym ? -longint'(h[NTAPS-1-k]) : longint'(h[NTAPS-1-k]);
      s += c * x;
    end
    return s;
  endfunction

  function automatic logic [DW-1:0] sample(input int pat, input int i);
    case (pat)
      0: return (i == 0) ? 8'sd1 : 8'sd0;
      1: return 8'h80;
      2: return DW'(((i * 37 + 11) * 97 + (i >> 2)) % 256);
      3: return (i % 2 == 0) ? 8'h7f : 8'h80;
      default: return 8'sd100;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    smp_valid = 1'b0;
    res_ready = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(res_valid == 1'b0, "R1 res_valid in reset", res_valid, 0);
    check(smp_ready == 1'b1, "R1 smp_ready in reset", smp_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    nacc = 0;
    nout = 0;
    #1;
    check(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);
  endtask

  task automatic run(input string req, input int pat, input int n,
                     input bit gaps, input bit stalls);
    int  sent = 0;
    bit  keep = 0;
    bit  held = 0;
    logic [AW-1:0] held_data = '0;
    int  guard = 0;
    while ((sent < n || nout < nacc) && guard < 4000) begin
      guard++;
      @(negedge clk);
      iter++;
      smp_valid = (sent < n) && (keep || !gaps || ($urandom_range(0, 3) != 0));
      smp_data  = sample(pat, sent);
      res_ready = !stalls || ($urandom_range(0, 2) != 0);
      #1;
      if (held) begin
        check(res_valid == 1'b1, "R7 valid held", res_valid, 1);
        check(res_data == held_data, "R7 data held", longint'($signed(res_data)),
              longint'($signed(held_data)));
      end
      if (res_valid && res_ready) begin
        check(nout < nacc, "R8 result without sample", nout, nacc);
        check($signed(res_data) == expq[nout], req, longint'($signed(res_data)), expq[nout]);
        if (!stalls)
          check(iter == acc_iter[nout] + LAT + 1, "R6 latency", iter - acc_iter[nout] - 1, LAT);
        nout++;
      end
      if (res_valid && !res_ready) begin
        check(smp_ready == 1'b0, "R7 smp_ready under stall", smp_ready, 0);
        held = 1;
        held_data = res_data;
      end else begin
        held = 0;
      end
      keep = smp_valid && !smp_ready;
      if (smp_valid && smp_ready) begin
        hist[nacc] = longint'($signed(smp_data));
        expq[nacc] = model(nacc);
        acc_iter[nacc] = iter;
        nacc++;
        sent++;
      end
      check(nacc - nout <= LAT + 1, "R9 outstanding", nacc - nout, LAT + 1);
    end
    @(negedge clk);
    smp_valid = 1'b0;
    res_ready = 1'b1;
    repeat (LAT + 3) begin
      @(negedge clk);
      iter++;
      #1;
      check(res_valid == 1'b0, "R8 no extra result", res_valid, 0);
    end
    check(nout == nacc, "R8 result count", nout, nacc);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    h[0] = 3; h[1] = -5; h[2] = 17; h[3] = 100;
    odd_sym = 1'b0;
    do_reset();
    run("R2 impulse even", 0, 10, 0, 0);
    do_reset();
    run("R2 step even", 4, 12, 0, 0);
    do_reset();
    run("R8 gapped even", 2, 80, 1, 0);
    do_reset();
    run("R7 stalled even", 2, 80, 1, 1);

    h[0] = -9; h[1] = 44; h[2] = -71; h[3] = 77;
    odd_sym = 1'b1;
    do_reset();
    run("R4 impulse odd centre", 0, 10, 0, 0);
    do_reset();
    run("R3 odd mixed", 2, 80, 1, 1);
    do_reset();
    run("R3 odd alternating", 3, 20, 0, 0);

    h[0] = -128; h[1] = -128; h[2] = -128; h[3] = -128;
    odd_sym = 1'b0;
    do_reset();
    run("R5 even extremes", 1, 12, 0, 0);
    odd_sym = 1'b1;
    do_reset();
    run("R5 odd extremes", 3, 16, 0, 1);

    h[0] = 0; h[1] = 0; h[2] = 0; h[3] = 55;
    odd_sym = 1'b0;
    do_reset();
    run("R4 centre alone even", 0, 10, 0, 0);

    finish_up();
  end

endmodule